// File: doc/BRIEF.md
# Snooping Virtually-Tagged Cache Directory

This block is the tag directory of a set-associative data cache. Each line's tag is built from the virtual address and an address-space context number, so a lookup needs no address translation. A lookup takes a virtual set index, a virtual tag and the current context. It returns hit and the hitting way two cycles later. A line hits only when it is valid and both its virtual tag and its stored context equal the request. The fill port installs a line into a way chosen outside the block and writes three things for it: the virtual tag, the context, and the line's physical tag.

The stored physical tags are kept in a separate array. Every write seen on the shared bus is compared against that array, including the processor's own writes. A match in the addressed set invalidates every matching way in one cycle. A physical line mapped through several virtual aliases can therefore sit in several ways, and all of those copies are dropped when the write appears on the bus. For a write issued by this processor, the way that its most recent store lookup hit in that set is left valid, because that copy was already updated locally. A flush request walks all sets, one per cycle, clearing valid bits. Software issues it before first use.

The set index is taken from address bits below the page boundary, so the virtual and physical index of a line are equal.

Top module: `snoop_dir`

## Requirements
- R1: After reset every line is invalid, and `lk_valid`, `lk_hit` and `flush_busy` are 0.
- R2: A lookup requested in cycle N (`lk_req`=1) is answered in cycle N+2: `lk_valid` is 1 in that cycle and 0 in cycle N+1.
- R3: A lookup hits only when a valid way of set `lk_idx` holds both `lk_vtag` and `lk_ctx`. `lk_way` gives that way in binary, and the lowest-numbered way wins when several match.
- R4: A fill (`fl_en`=1) makes way `fl_way` of set `fl_idx` valid with the given tags from the next cycle on. Two ways may hold the same physical tag at the same time.
- R5: A bus write (`sn_valid`=1) from a master other than `SELF_ID` (default 0) invalidates every way of set `sn_addr[OFF_W+IDX_W-1:OFF_W]` whose physical tag equals `sn_addr[PADDR_W-1:OFF_W+IDX_W]`. Lookups issued from the next cycle on see the change.
- R6: A bus write whose physical tag matches no way of its set, or that addresses a different set, leaves every line unchanged.
- R7: A bus write from master `SELF_ID` invalidates matching ways in the same way, except the way hit by the most recent lookup with `lk_store`=1 in that set.
- R8: When a fill and a matching bus write address the same set and way in the same cycle, the line ends invalid. A non-matching write leaves the fill valid.
- R9: A flush request raises `flush_busy` in the next cycle. `flush_busy` stays high for exactly SETS cycles, and afterwards every line is invalid.
- R10: A lookup requested while a flush is pending or running reports a miss. A fill requested then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | IDX_W | Lookup set index |
| lk_vtag | input | VTAG_W | Lookup virtual tag |
| lk_ctx | input | CTX_W | Current context number |
| lk_store | input | 1 | Lookup belongs to a store; a hit is remembered for own-write snooping |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Hitting way |
| fl_en | input | 1 | Fill strobe |
| fl_idx | input | IDX_W | Fill set index |
| fl_way | input | WAY_W | Fill way |
| fl_vtag | input | VTAG_W | Virtual tag to install |
| fl_ctx | input | CTX_W | Context to install |
| fl_ptag | input | PTAG_W | Physical tag to install |
| sn_valid | input | 1 | Bus write observed |
| sn_addr | input | PADDR_W | Physical write address |
| sn_master | input | MID_W | Writing master number |
| flush_req | input | 1 | Start invalidating all lines |
| flush_busy | output | 1 | Flush walk in progress |

## Verification
A valid bit left set by mistake shows up as a false hit, and a lost one as a spurious miss. Either appears on `lk_hit` two cycles after the next lookup of that set. A stored physical tag that is wrong stays hidden until a bus write addresses that set. After the write, the next lookup of the affected line shows a stale hit or a missing invalidation. Because of this, each snoop in the bench is followed by lookups of both the targeted and the untouched aliases. A faulty flush walk leaves one set still live. It is exposed by the busy-cycle count and by the lookup of a line filled before the flush.

// File: rtl/snoop_dir_pkg.sv
package snoop_dir_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_t;

endpackage

// File: rtl/snoop_dir_tag_ram.sv
// Synchronous-read tag store, one per way; shaped for block RAM inference.
module snoop_dir_tag_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 28,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/snoop_dir_ptag_ram.sv
// Physical tag store with combinational read, so a bus write is resolved
// in the cycle it is observed (distributed RAM style).
module snoop_dir_ptag_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 23,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/snoop_dir_flush.sv
// Walks every set once, one per cycle, after a flush request.
module snoop_dir_flush
  import snoop_dir_pkg::*;
#(
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_req,
  output logic             busy,
  output logic [IDX_W-1:0] wipe_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  walk_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WALK_IDLE;
      wipe_idx <= '0;
    end else begin
      case (state)
        WALK_IDLE: begin
          if (flush_req) begin
            state    <= WALK_RUN;
            wipe_idx <= '0;
          end
        end
        WALK_RUN: begin
          if (wipe_idx == LAST) state <= WALK_IDLE;
          else                  wipe_idx <= wipe_idx + 1'b1;
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  assign busy = (state == WALK_RUN);

  // R9
  flush_start_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !busy) |=> busy);

endmodule

// File: rtl/snoop_dir_valid.sv
// Valid bits as flops: any number of ways per set may be cleared at once.
module snoop_dir_valid #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAY_W-1:0] set_way,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [WAYS-1:0]  clr_ways,
  input  logic             wipe_en,
  input  logic [IDX_W-1:0] wipe_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAYS-1:0]  rd_ways
);

  logic [SETS-1:0][WAYS-1:0] vld;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0] add_m, kill_m;
    always_comb begin
      add_m  = '0;
      kill_m = '0;
      if (set_en && set_idx == IDX_W'(s)) add_m[set_way] = 1'b1;
      if (clr_idx == IDX_W'(s))           kill_m = clr_ways;
      if (wipe_en && wipe_idx == IDX_W'(s)) kill_m = '1;
    end
    // Invalidation is applied after the fill, so it wins.
    always_ff @(posedge clk) begin
      if (rst) vld[s] <= '0;
      else     vld[s] <= (vld[s] | add_m) & ~kill_m;
    end
  end

  assign rd_ways = vld[rd_idx];

  // R9
  flush_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wipe_en) |-> (vld == '0));

endmodule

// File: rtl/snoop_dir.sv
module snoop_dir #(
  parameter int SETS    = 16,
  parameter int WAYS    = 4,
  parameter int VTAG_W  = 20,
  parameter int CTX_W   = 8,
  parameter int PADDR_W = 32,
  parameter int OFF_W   = 5,
  parameter int MID_W   = 4,
  parameter int SELF_ID = 0,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int PTAG_W = PADDR_W - OFF_W - IDX_W,
  localparam int TAG_W  = VTAG_W + CTX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [VTAG_W-1:0]  lk_vtag,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic               lk_store,
  output logic               lk_valid,
  output logic               lk_hit,
  output logic [WAY_W-1:0]   lk_way,
  input  logic               fl_en,
  input  logic [IDX_W-1:0]   fl_idx,
  input  logic [WAY_W-1:0]   fl_way,
  input  logic [VTAG_W-1:0]  fl_vtag,
  input  logic [CTX_W-1:0]   fl_ctx,
  input  logic [PTAG_W-1:0]  fl_ptag,
  input  logic               sn_valid,
  input  logic [PADDR_W-1:0] sn_addr,
  input  logic [MID_W-1:0]   sn_master,
  input  logic               flush_req,
  output logic               flush_busy
);

  logic             wipe_busy;
  logic [IDX_W-1:0] wipe_idx;
  logic             fill_ok;
  logic [IDX_W-1:0] sn_set;
  logic [PTAG_W-1:0] sn_ptag;
  logic             sn_own;

  logic [WAYS-1:0][TAG_W-1:0]  tag_rd;
  logic [WAYS-1:0][PTAG_W-1:0] ptag_rd;
  logic [WAYS-1:0]             snp_kill;
  logic [WAYS-1:0]             vld_rd;

  // store-hit record, spared by this processor's own bus writes
  logic             rec_v;
  logic [IDX_W-1:0] rec_set;
  logic [WAY_W-1:0] rec_way;

  // lookup stage 1
  logic              s1_req, s1_block, s1_store;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_key;
  logic [WAYS-1:0]   s1_vld;
  logic [WAYS-1:0]   s1_match;
  logic              s1_any;
  logic [WAY_W-1:0]  s1_way;

  assign fill_ok = fl_en && !wipe_busy && !flush_req;
  assign sn_set  = sn_addr[OFF_W +: IDX_W];
  assign sn_ptag = sn_addr[PADDR_W-1 -: PTAG_W];
  assign sn_own  = (sn_master == MID_W'(SELF_ID));

  snoop_dir_flush #(.SETS(SETS)) u_flush (
    .clk       (clk),
    .rst       (rst),
    .flush_req (flush_req),
    .busy      (wipe_busy),
    .wipe_idx  (wipe_idx)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_this, byp;
    logic [PTAG_W-1:0] cmp_ptag;
    logic spare;

    assign wr_this = fill_ok && (fl_way == WAY_W'(w));

    snoop_dir_tag_ram #(.DEPTH(SETS), .W(TAG_W)) u_tag (
      .clk   (clk),
      .we    (wr_this),
      .waddr (fl_idx),
      .wdata ({fl_vtag, fl_ctx}),
      .re    (lk_req),
      .raddr (lk_idx),
      .rdata (tag_rd[w])
    );

    snoop_dir_ptag_ram #(.DEPTH(SETS), .W(PTAG_W)) u_ptag (
      .clk   (clk),
      .we    (wr_this),
      .waddr (fl_idx),
      .wdata (fl_ptag),
      .raddr (sn_set),
      .rdata (ptag_rd[w])
    );

    // A fill landing in the snooped set this cycle is compared by its new tag.
    assign byp      = wr_this && (fl_idx == sn_set);
    assign cmp_ptag = byp ? fl_ptag : ptag_rd[w];
    assign spare    = sn_own && rec_v && !byp && (rec_set == sn_set) &&
                      (rec_way == WAY_W'(w));
    assign snp_kill[w] = sn_valid && (cmp_ptag == sn_ptag) && !spare;

    assign s1_match[w] = s1_vld[w] && (tag_rd[w] == s1_key);
  end

  snoop_dir_valid #(.SETS(SETS), .WAYS(WAYS)) u_valid (
    .clk      (clk),
    .rst      (rst),
    .set_en   (fill_ok),
    .set_idx  (fl_idx),
    .set_way  (fl_way),
    .clr_idx  (sn_set),
    .clr_ways (snp_kill),
    .wipe_en  (wipe_busy),
    .wipe_idx (wipe_idx),
    .rd_idx   (lk_idx),
    .rd_ways  (vld_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_req   <= 1'b0;
      s1_block <= 1'b0;
      s1_store <= 1'b0;
      s1_idx   <= '0;
      s1_key   <= '0;
      s1_vld   <= '0;
    end else begin
      s1_req   <= lk_req;
      s1_block <= wipe_busy || flush_req;
      s1_store <= lk_store;
      s1_idx   <= lk_idx;
      s1_key   <= {lk_vtag, lk_ctx};
      s1_vld   <= vld_rd;
    end
  end

  // lowest matching way wins
  always_comb begin
    s1_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (s1_match[w]) s1_way = WAY_W'(w);
    end
    s1_any = (|s1_match) && !s1_block;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_way   <= '0;
    end else begin
      lk_valid <= s1_req;
      lk_hit   <= s1_req && s1_any;
      lk_way   <= s1_any ? s1_way : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_v   <= 1'b0;
      rec_set <= '0;
      rec_way <= '0;
    end else if (flush_req || wipe_busy) begin
      rec_v <= 1'b0;
    end else if (s1_req && s1_any && s1_store) begin
      rec_v   <= 1'b1;
      rec_set <= s1_idx;
      rec_way <= s1_way;
    end else if (fill_ok && rec_v && fl_idx == rec_set && fl_way == rec_way) begin
      rec_v <= 1'b0;
    end
  end

  assign flush_busy = wipe_busy;

  // R3
  hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_valid);

  // R2
  lk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $past(lk_req, 2));

  // R10
  miss_during_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush_req || flush_busy, 2) |-> !lk_hit);

endmodule

// File: tb/snoop_dir_bench.sv
module snoop_dir_bench;

  localparam int IDX_W = 4, WAY_W = 2, VTAG_W = 20, CTX_W = 8;
  localparam int PADDR_W = 32, OFF_W = 5, MID_W = 4, PTAG_W = 23;

  logic clk = 0, rst = 1;
  logic lk_req = 0, lk_store = 0, lk_valid, lk_hit;
  logic [IDX_W-1:0] lk_idx = '0;
  logic [VTAG_W-1:0] lk_vtag = '0;
  logic [CTX_W-1:0] lk_ctx = '0;
  logic [WAY_W-1:0] lk_way;
  logic fl_en = 0;
  logic [IDX_W-1:0] fl_idx = '0;
  logic [WAY_W-1:0] fl_way = '0;
  logic [VTAG_W-1:0] fl_vtag = '0;
  logic [CTX_W-1:0] fl_ctx = '0;
  logic [PTAG_W-1:0] fl_ptag = '0;
  logic sn_valid = 0;
  logic [PADDR_W-1:0] sn_addr = '0;
  logic [MID_W-1:0] sn_master = '0;
  logic flush_req = 0, flush_busy;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  snoop_dir u_snoop_dir (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_idx(lk_idx), .lk_vtag(lk_vtag), .lk_ctx(lk_ctx),
    .lk_store(lk_store), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_way(lk_way),
    .fl_en(fl_en), .fl_idx(fl_idx), .fl_way(fl_way), .fl_vtag(fl_vtag),
    .fl_ctx(fl_ctx), .fl_ptag(fl_ptag),
    .sn_valid(sn_valid), .sn_addr(sn_addr), .sn_master(sn_master),
    .flush_req(flush_req), .flush_busy(flush_busy)
  );

  typedef struct packed {
    logic [1:0]        op;     // 0 fill, 1 lookup, 2 bus write
    logic [IDX_W-1:0]  idx;
    logic [WAY_W-1:0]  way;
    logic [VTAG_W-1:0] vtag;
    logic [CTX_W-1:0]  ctx;
    logic [PTAG_W-1:0] ptag;
    logic [MID_W-1:0]  mid;
    logic              store;
    logic              ehit;
    logic [WAY_W-1:0]  eway;
    logic [3:0]        req;
  } vec_t;

  localparam logic [VTAG_W-1:0] VA = 20'hA1111, VB = 20'hB2222,
                                VC = 20'hC3333, VD = 20'hD4444;
  localparam logic [PTAG_W-1:0] P1 = 23'h12345, P2 = 23'h2ABCD, P3 = 23'h3F00F;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd3, 2'd0, VA, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd1},  // R1 empty
    '{2'd0, 4'd3, 2'd0, VA, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd4},
    '{2'd1, 4'd3, 2'd0, VA, 8'd1, P1, 4'd0, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 hit
    '{2'd1, 4'd3, 2'd0, VA, 8'd2, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd3},  // R3 context
    '{2'd1, 4'd3, 2'd0, VB, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd3},  // R3 vtag
    '{2'd0, 4'd3, 2'd2, VB, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 alias
    '{2'd1, 4'd3, 2'd0, VB, 8'd1, P1, 4'd0, 1'b0, 1'b1, 2'd2, 4'd4},
    '{2'd1, 4'd3, 2'd0, VA, 8'd1, P1, 4'd0, 1'b0, 1'b1, 2'd0, 4'd4},
    '{2'd2, 4'd3, 2'd0, VA, 8'd0, P1, 4'd5, 1'b0, 1'b0, 2'd0, 4'd5},  // R5
    '{2'd1, 4'd3, 2'd0, VA, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd5},
    '{2'd1, 4'd3, 2'd0, VB, 8'd1, P1, 4'd0, 1'b0, 1'b0, 2'd0, 4'd5},
    '{2'd0, 4'd5, 2'd1, VC, 8'd3, P2, 4'd0, 1'b0, 1'b0, 2'd0, 4'd4},
    '{2'd0, 4'd5, 2'd3, VD, 8'd3, P2, 4'd0, 1'b0, 1'b0, 2'd0, 4'd4},
    '{2'd1, 4'd5, 2'd0, VC, 8'd3, P2, 4'd0, 1'b1, 1'b1, 2'd1, 4'd7},  // R7 store
    '{2'd2, 4'd5, 2'd0, VC, 8'd0, P2, 4'd0, 1'b0, 1'b0, 2'd0, 4'd7},  // own write
    '{2'd1, 4'd5, 2'd0, VC, 8'd3, P2, 4'd0, 1'b0, 1'b1, 2'd1, 4'd7},
    '{2'd1, 4'd5, 2'd0, VD, 8'd3, P2, 4'd0, 1'b0, 1'b0, 2'd0, 4'd7},
    '{2'd2, 4'd5, 2'd0, VC, 8'd0, P3, 4'd5, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 tag
    '{2'd1, 4'd5, 2'd0, VC, 8'd3, P2, 4'd0, 1'b0, 1'b1, 2'd1, 4'd6},
    '{2'd2, 4'd6, 2'd0, VC, 8'd0, P2, 4'd5, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 set
    '{2'd1, 4'd5, 2'd0, VC, 8'd3, P2, 4'd0, 1'b0, 1'b1, 2'd1, 4'd6},
    '{2'd0, 4'd9, 2'd2, VA, 8'd1, P3, 4'd0, 1'b0, 1'b0, 2'd0, 4'd3},
    '{2'd0, 4'd9, 2'd1, VA, 8'd1, P3, 4'd0, 1'b0, 1'b0, 2'd0, 4'd3},
    '{2'd1, 4'd9, 2'd0, VA, 8'd1, P3, 4'd0, 1'b0, 1'b1, 2'd1, 4'd3}   // R3 lowest
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [IDX_W-1:0] i, input logic [WAY_W-1:0] w,
                         input logic [VTAG_W-1:0] v, input logic [CTX_W-1:0] c,
                         input logic [PTAG_W-1:0] p);
    @(negedge clk);
    fl_en = 1; fl_idx = i; fl_way = w; fl_vtag = v; fl_ctx = c; fl_ptag = p;
    @(negedge clk);
    fl_en = 0;
  endtask

  task automatic do_snoop(input logic [IDX_W-1:0] i, input logic [PTAG_W-1:0] p,
                          input logic [MID_W-1:0] m);
    @(negedge clk);
    sn_valid = 1; sn_addr = {p, i, 5'd0}; sn_master = m;
    @(negedge clk);
    sn_valid = 0;
  endtask

  task automatic do_lookup(input logic [IDX_W-1:0] i, input logic [VTAG_W-1:0] v,
                           input logic [CTX_W-1:0] c, input logic st,
                           input logic eh, input logic [WAY_W-1:0] ew, input string tag);
    @(negedge clk);
    lk_req = 1; lk_idx = i; lk_vtag = v; lk_ctx = c; lk_store = st;
    @(negedge clk);
    lk_req = 0; lk_store = 0;
    check(lk_valid == 1'b0, "R2 early valid", lk_valid, 0);
    @(negedge clk);
    check(lk_valid == 1'b1, "R2 valid", lk_valid, 1);
    check(lk_hit == eh, {tag, " hit"}, lk_hit, eh);
    if (eh) check(lk_way == ew, {tag, " way"}, lk_way, ew);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(lk_valid == 0, "R1 lk_valid", lk_valid, 0);
    check(lk_hit == 0, "R1 lk_hit", lk_hit, 0);
    check(flush_busy == 0, "R1 flush_busy", flush_busy, 0);

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        2'd0: do_fill(VECS[k].idx, VECS[k].way, VECS[k].vtag, VECS[k].ctx, VECS[k].ptag);
        2'd2: do_snoop(VECS[k].idx, VECS[k].ptag, VECS[k].mid);
        default: do_lookup(VECS[k].idx, VECS[k].vtag, VECS[k].ctx, VECS[k].store,
                           VECS[k].ehit, VECS[k].eway,
                           $sformatf("vec%0d R%0d", k, VECS[k].req));
      endcase
    end

    // R8 same-cycle fill and matching bus write
    @(negedge clk);
    fl_en = 1; fl_idx = 4'd7; fl_way = 2'd0; fl_vtag = VD; fl_ctx = 8'd4; fl_ptag = P1;
    sn_valid = 1; sn_addr = {P1, 4'd7, 5'd0}; sn_master = 4'd5;
    @(negedge clk);
    fl_en = 0; sn_valid = 0;
    do_lookup(4'd7, VD, 8'd4, 1'b0, 1'b0, 2'd0, "R8 killed");
    @(negedge clk);
    fl_en = 1; fl_ptag = P2;
    sn_valid = 1; sn_addr = {P1, 4'd7, 5'd0};
    @(negedge clk);
    fl_en = 0; sn_valid = 0;
    do_lookup(4'd7, VD, 8'd4, 1'b0, 1'b1, 2'd0, "R8 kept");

    // R9 flush duration and clean result
    do_fill(4'd12, 2'd3, VC, 8'd2, P3);
    do_lookup(4'd12, VC, 8'd2, 1'b0, 1'b1, 2'd3, "R4 pre-flush");
    @(negedge clk);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    n = 0;
    while (flush_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == 16, "R9 busy cycles", n, 16);
    do_lookup(4'd12, VC, 8'd2, 1'b0, 1'b0, 2'd0, "R9 after flush");
    do_lookup(4'd7, VD, 8'd4, 1'b0, 1'b0, 2'd0, "R9 after flush");

    // R10 lookup in request cycle of a flush, and a fill during the walk
    do_fill(4'd12, 2'd3, VC, 8'd2, P3);
    @(negedge clk);
    flush_req = 1;
    lk_req = 1; lk_idx = 4'd12; lk_vtag = VC; lk_ctx = 8'd2;
    @(negedge clk);
    flush_req = 0; lk_req = 0;
    check(flush_busy == 1, "R9 busy rise", flush_busy, 1);
    @(negedge clk);
    check(lk_valid == 1, "R10 valid", lk_valid, 1);
    check(lk_hit == 0, "R10 miss in flush", lk_hit, 0);
    do_fill(4'd13, 2'd0, VB, 8'd6, P2);
    n = 0;
    while (flush_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    do_lookup(4'd13, VB, 8'd6, 1'b0, 1'b0, 2'd0, "R10 fill ignored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule